// File: doc/BRIEF.md
# Programmable Parallel I/O Port

This block gives a processor 24 general-purpose I/O lines. The lines form two byte-wide ports, P0 and P1, and a third byte-wide port, P2, whose two nibbles can be set up separately. The lines fall into two groups of twelve. Group X holds P0 and the upper nibble of P2. Group Y holds P1 and the lower nibble of P2. The processor reaches the block through a small synchronous register interface. Each access lasts one cycle and is qualified by `cs` with `rd` or `wr`. A 2-bit address selects P0, P1, P2 or the control register.

A control write with bit 7 set is a mode definition. It sets the operating mode and direction of both groups. Mode 0 is plain latched output or direct pin input. Mode 1 is strobed transfer in one direction, with handshake and interrupt signals taken from P2. Mode 2 is available to group X only. It makes P0 a bidirectional strobed bus and takes one extra P2 line from group Y. A control write with bit 7 clear sets or clears one P2 latch bit.

Pin drivers are not part of the block. Each line appears as separate input, output and output-enable bits.

Top module: `ppio_port`

## Requirements
- R1: After reset, all output enables are 0, `rdata` is 0, the P0/P1/P2 latches are 0, and both groups are in mode 0 input.
- R2: A control write (address 3) with bit 7 = 1 loads the configuration as follows: bits 6:5 are the group X mode (00 = mode 0, 01 = mode 1, 1x = mode 2); bit 4 is the P0 direction; bit 3 is the P2[7:4] direction; bit 2 is the group Y mode (0/1); bit 1 is the P1 direction; bit 0 is the P2[3:0] direction. For each direction bit, 1 = input. The write also clears all three output latches. In the cycle after the write every output enable is 0. The new directions apply from the following cycle.
- R3: In mode 0, an output port drives its latch with the enable set to 1, and reading it returns the latch. An input port has its enable at 0, and reading it returns its pins.
- R4: A control write with bit 7 = 0 sets P2 latch bit number wdata[3:1] to wdata[0] and leaves the other seven latch bits unchanged.
- R5: A read (`cs` and `rd` with `wr` low) loads `rdata` at the clock edge. `rdata` holds between reads. Address 3 reads as 0.
- R6: In group Y mode 1 input, a falling edge on P2[2] captures P1's pins and drives P2[1] (buffer full) high. A read of P1 returns the captured byte and returns P2[1] to low.
- R7: P2[0] is the group Y interrupt. It equals latch bit P2[2] ANDed with the pending condition. For input, the condition is buffer full. For output, it is that an acknowledge has arrived since the last write.
- R8: In group Y mode 1 output, a write to P1 drives P2[1] (output full, active low) low. A falling edge on P2[2] returns it high and raises the interrupt if enabled. The next write drops the interrupt.
- R9: In group X mode 1 input, P2[4] is the strobe, P2[5] is buffer full and P2[3] is the interrupt, enabled by latch bit P2[4]. Reading P0 returns the captured byte.
- R10: In group X mode 1 output, P2[6] is the acknowledge and P2[7] is output full (active low). P2[3] is the interrupt, enabled by latch bit P2[6].
- R11: In group X mode 2, P0 is driven only while the P2[6] pin is low. Both the input and the output handshakes work, and P2[3] is the OR of the two interrupts.
- R12: Reading P2 returns, for each bit, the value the block drives if its enable is 1, and the pin otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Access select |
| rd | input | 1 | Read request |
| wr | input | 1 | Write request |
| addr | input | 2 | 0 = P0, 1 = P1, 2 = P2, 3 = control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| p0_in | input | 8 | P0 pin levels |
| p0_out | output | 8 | P0 drive values |
| p0_oe | output | 8 | P0 output enables |
| p1_in | input | 8 | P1 pin levels |
| p1_out | output | 8 | P1 drive values |
| p1_oe | output | 8 | P1 output enables |
| p2_in | input | 8 | P2 pin levels |
| p2_out | output | 8 | P2 drive values |
| p2_oe | output | 8 | P2 output enables |

## Verification
Some behaviours are checked on every cycle:
- all enables are released in the cycle after a mode definition;
- a single-bit command lands on the addressed latch bit;
- in mode 2, the P0 enable follows the acknowledge pin;
- a strobe edge sets the full flag, a write drops the output-full pin and an acknowledge edge raises it again.

The bench's scenarios cover the rest:
- the direction and read-back behaviour across random mode 0 configurations;
- the captured data returned by reads;
- the gating of each interrupt by its enable bit;
- the combined interrupt of the bidirectional mode over a full transfer in each direction.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
    localparam int PW = 8;
    localparam int BW = $clog2(PW);

    typedef enum logic [1:0] {
        ADR_P0  = 2'd0,
        ADR_P1  = 2'd1,
        ADR_P2  = 2'd2,
        ADR_CTL = 2'd3
    } adr_e;

    // configuration fields, in the order of control word bits 6..0
    typedef struct packed {
        logic [1:0] xmode;
        logic       x_in;
        logic       xu_in;
        logic       ymode;
        logic       y_in;
        logic       yl_in;
    } cfg_t;

    localparam cfg_t CFG_RST = '{xmode: 2'b00, x_in: 1'b1, xu_in: 1'b1,
                                 ymode: 1'b0, y_in: 1'b1, yl_in: 1'b1};

    // P2 bit roles in handshake modes
    localparam int Y_IRQ  = 0;
    localparam int Y_FLG  = 1;
    localparam int Y_STB  = 2;
    localparam int X_IRQ  = 3;
    localparam int X_ISTB = 4;
    localparam int X_IBF  = 5;
    localparam int X_ACK  = 6;
    localparam int X_OBF  = 7;

    // handshake channel index
    localparam int CH_XI = 0;
    localparam int CH_XO = 1;
    localparam int CH_YI = 2;
    localparam int CH_YO = 3;
    localparam int NCH   = 4;
endpackage

// File: rtl/ppio_hs_chan.sv
module ppio_hs_chan #(
    parameter bit OUTBOUND = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic arm,
    input  logic disarm,
    input  logic ien,
    output logic full,
    output logic irq
);
    typedef struct packed {
        logic full;
        logic done;
    } ch_t;

    ch_t q, d;

    always_comb begin
        d = q;
        if (flush) begin
            d = '0;
        end else begin
            if (disarm) begin
                d.full = 1'b0;
                d.done = 1'b1;
            end
            if (arm) begin
                d.full = 1'b1;
                d.done = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign full = q.full;
    assign irq  = ien & (OUTBOUND ? (!q.full & q.done) : q.full);
endmodule

// File: rtl/ppio_drive.sv
module ppio_drive
    import ppio_pkg::*;
(
    input  cfg_t          cfg,
    input  logic          settle,
    input  logic [PW-1:0] lat0,
    input  logic [PW-1:0] lat1,
    input  logic [PW-1:0] lat2,
    input  logic          ack_x_n,
    input  logic          xi_full,
    input  logic          xo_full,
    input  logic          yi_full,
    input  logic          yo_full,
    input  logic          x_irq,
    input  logic          y_irq,
    output logic [PW-1:0] p0_out,
    output logic [PW-1:0] p0_oe,
    output logic [PW-1:0] p1_out,
    output logic [PW-1:0] p1_oe,
    output logic [PW-1:0] p2_out,
    output logic [PW-1:0] p2_oe
);
    localparam int NW = PW / 2;

    logic xm1, xm2;

    always_comb begin
        xm1    = (cfg.xmode == 2'b01);
        xm2    = cfg.xmode[1];
        p0_out = lat0;
        p1_out = lat1;
        p2_out = lat2;
        p0_oe  = xm2 ? {PW{!ack_x_n}} : {PW{!cfg.x_in}};
        p1_oe  = {PW{!cfg.y_in}};
        p2_oe  = {{NW{!cfg.xu_in}}, {NW{!cfg.yl_in}}};

        if (cfg.ymode) begin
            p2_oe[Y_STB]  = 1'b0;
            p2_oe[Y_FLG]  = 1'b1;
            p2_out[Y_FLG] = cfg.y_in ? yi_full : !yo_full;
            p2_oe[Y_IRQ]  = 1'b1;
            p2_out[Y_IRQ] = y_irq;
        end
        if (xm1 || xm2) begin
            p2_oe[X_IRQ]  = 1'b1;
            p2_out[X_IRQ] = x_irq;
            if (xm2 || cfg.x_in) begin
                p2_oe[X_ISTB] = 1'b0;
                p2_oe[X_IBF]  = 1'b1;
                p2_out[X_IBF] = xi_full;
            end
            if (xm2 || !cfg.x_in) begin
                p2_oe[X_ACK]  = 1'b0;
                p2_oe[X_OBF]  = 1'b1;
                p2_out[X_OBF] = !xo_full;
            end
        end
        if (settle) begin
            p0_oe = '0;
            p1_oe = '0;
            p2_oe = '0;
        end
    end
endmodule

// File: rtl/ppio_port.sv
module ppio_port
    import ppio_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          rd,
    input  logic          wr,
    input  logic [1:0]    addr,
    input  logic [PW-1:0] wdata,
    output logic [PW-1:0] rdata,
    input  logic [PW-1:0] p0_in,
    output logic [PW-1:0] p0_out,
    output logic [PW-1:0] p0_oe,
    input  logic [PW-1:0] p1_in,
    output logic [PW-1:0] p1_out,
    output logic [PW-1:0] p1_oe,
    input  logic [PW-1:0] p2_in,
    output logic [PW-1:0] p2_out,
    output logic [PW-1:0] p2_oe
);
    typedef struct packed {
        cfg_t          cfg;
        logic          settle;
        logic [PW-1:0] lat0;
        logic [PW-1:0] lat1;
        logic [PW-1:0] lat2;
        logic [PW-1:0] cap0;
        logic [PW-1:0] cap1;
        logic [PW-1:0] rdata;
        logic [2:0]    prev;
    } st_t;

    st_t q, d;

    logic           wr_en, rd_en, flush, xm1, xm2;
    logic [2:0]     hs_pins, fall;
    logic [NCH-1:0] arm, dis, ien, full, irq;
    logic           x_irq, y_irq;

    // access decode and handshake events
    always_comb begin
        wr_en   = cs & wr;
        rd_en   = cs & rd & ~wr;
        flush   = wr_en & (addr == ADR_CTL) & wdata[PW-1];
        xm1     = (q.cfg.xmode == 2'b01);
        xm2     = q.cfg.xmode[1];
        hs_pins = {p2_in[Y_STB], p2_in[X_ACK], p2_in[X_ISTB]};
        fall    = q.prev & ~hs_pins;

        arm[CH_XI] = (xm2 | (xm1 & q.cfg.x_in)) & fall[0];
        dis[CH_XI] = (xm2 | (xm1 & q.cfg.x_in)) & rd_en & (addr == ADR_P0);
        arm[CH_XO] = (xm2 | (xm1 & ~q.cfg.x_in)) & wr_en & (addr == ADR_P0);
        dis[CH_XO] = (xm2 | (xm1 & ~q.cfg.x_in)) & fall[1];
        arm[CH_YI] = q.cfg.ymode & q.cfg.y_in & fall[2];
        dis[CH_YI] = q.cfg.ymode & q.cfg.y_in & rd_en & (addr == ADR_P1);
        arm[CH_YO] = q.cfg.ymode & ~q.cfg.y_in & wr_en & (addr == ADR_P1);
        dis[CH_YO] = q.cfg.ymode & ~q.cfg.y_in & fall[2];

        ien[CH_XI] = q.lat2[X_ISTB];
        ien[CH_XO] = q.lat2[X_ACK];
        ien[CH_YI] = q.lat2[Y_STB];
        ien[CH_YO] = q.lat2[Y_STB];

        x_irq = xm2 ? (irq[CH_XI] | irq[CH_XO])
                    : (q.cfg.x_in ? irq[CH_XI] : irq[CH_XO]);
        y_irq = q.cfg.y_in ? irq[CH_YI] : irq[CH_YO];
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        ppio_hs_chan #(.OUTBOUND(g % 2 == 1)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .flush  (flush),
            .arm    (arm[g]),
            .disarm (dis[g]),
            .ien    (ien[g]),
            .full   (full[g]),
            .irq    (irq[g])
        );
    end

    ppio_drive u_drive (
        .cfg     (q.cfg),
        .settle  (q.settle),
        .lat0    (q.lat0),
        .lat1    (q.lat1),
        .lat2    (q.lat2),
        .ack_x_n (p2_in[X_ACK]),
        .xi_full (full[CH_XI]),
        .xo_full (full[CH_XO]),
        .yi_full (full[CH_YI]),
        .yo_full (full[CH_YO]),
        .x_irq   (x_irq),
        .y_irq   (y_irq),
        .p0_out  (p0_out),
        .p0_oe   (p0_oe),
        .p1_out  (p1_out),
        .p1_oe   (p1_oe),
        .p2_out  (p2_out),
        .p2_oe   (p2_oe)
    );

    // next state
    always_comb begin
        d        = q;
        d.prev   = hs_pins;
        d.settle = 1'b0;
        if (arm[CH_XI]) d.cap0 = p0_in;
        if (arm[CH_YI]) d.cap1 = p1_in;

        if (wr_en) begin
            case (adr_e'(addr))
                ADR_P0: d.lat0 = wdata;
                ADR_P1: d.lat1 = wdata;
                ADR_P2: d.lat2 = wdata;
                ADR_CTL: begin
                    if (wdata[PW-1]) begin
                        d.cfg    = cfg_t'(wdata[PW-2:0]);
                        d.lat0   = '0;
                        d.lat1   = '0;
                        d.lat2   = '0;
                        d.settle = 1'b1;
                    end else begin
                        d.lat2[wdata[BW:1]] = wdata[0];
                    end
                end
                default: ;
            endcase
        end

        if (rd_en) begin
            case (adr_e'(addr))
                ADR_P0:  d.rdata = xm2 ? q.cap0
                                 : (q.cfg.x_in ? (xm1 ? q.cap0 : p0_in) : q.lat0);
                ADR_P1:  d.rdata = q.cfg.y_in ? (q.cfg.ymode ? q.cap1 : p1_in) : q.lat1;
                ADR_P2:  d.rdata = (p2_oe & p2_out) | (~p2_oe & p2_in);
                default: d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cfg  <= CFG_RST;
            q.prev <= '1;
        end else begin
            q <= d;
        end
    end

    assign rdata = q.rdata;
endmodule

// File: rtl/ppio_chk.sv
module ppio_chk
    import ppio_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          cs,
    input logic          wr,
    input logic [1:0]    addr,
    input logic [PW-1:0] wdata,
    input logic [PW-1:0] p0_oe,
    input logic [PW-1:0] p1_oe,
    input logic [PW-1:0] p2_oe,
    input logic [PW-1:0] p2_in,
    input logic [PW-1:0] p2_out,
    input cfg_t          cfg,
    input logic          settle,
    input logic [PW-1:0] lat2
);
    logic mode_wr, bsr_wr, p0_wr, p1_wr, xo_act;

    always_comb begin
        mode_wr = cs && wr && (addr == 2'd3) && wdata[PW-1];
        bsr_wr  = cs && wr && (addr == 2'd3) && !wdata[PW-1];
        p0_wr   = cs && wr && (addr == 2'd0);
        p1_wr   = cs && wr && (addr == 2'd1);
        xo_act  = cfg.xmode[1] || ((cfg.xmode == 2'b01) && !cfg.x_in);
    end

    assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (p0_oe == '0 && p1_oe == '0 && p2_oe == '0));

    assert_bitcmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bsr_wr |=> (lat2[$past(wdata[BW:1])] == $past(wdata[0])));

    assert_bidir_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.xmode[1] && !settle) |-> (p0_oe == {PW{!p2_in[X_ACK]}}));

    assert_obf_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_wr && cfg.ymode && !cfg.y_in) |=> !p2_out[Y_FLG]);

    assert_ibf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(p2_in[Y_STB]) && cfg.ymode && cfg.y_in && !mode_wr) |=> p2_out[Y_FLG]);

    assert_ack_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(p2_in[X_ACK]) && xo_act && !p0_wr && !mode_wr) |=> p2_out[X_OBF]);
endmodule

bind ppio_port ppio_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs     (cs),
    .wr     (wr),
    .addr   (addr),
    .wdata  (wdata),
    .p0_oe  (p0_oe),
    .p1_oe  (p1_oe),
    .p2_oe  (p2_oe),
    .p2_in  (p2_in),
    .p2_out (p2_out),
    .cfg    (q.cfg),
    .settle (q.settle),
    .lat2   (q.lat2)
);

// File: tb/ppio_port_test.sv
`timescale 1ns/1ps
module ppio_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] p0_in = '0, p1_in = '0, p2_in = '1;
    logic [7:0] p0_out, p0_oe, p1_out, p1_oe, p2_out, p2_oe;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    ppio_port uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata),
        .p0_in(p0_in), .p0_out(p0_out), .p0_oe(p0_oe),
        .p1_in(p1_in), .p1_out(p1_out), .p1_oe(p1_oe),
        .p2_in(p2_in), .p2_out(p2_out), .p2_oe(p2_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cpu_wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic cpu_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; addr = a;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
        v = rdata;
    endtask

    task automatic pulse(input int b);
        @(negedge clk);
        p2_in[b] = 1'b0;
        @(negedge clk);
        p2_in[b] = 1'b1;
    endtask

    function automatic logic [7:0] exp_p2oe(input logic xu, input logic yl);
        return {{4{!xu}}, {4{!yl}}};
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] oe, input logic [7:0] drv,
                                          input logic [7:0] pin);
        return (oe & drv) | (~oe & pin);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] r, m0, m1, m2, cw, eo2, model, hold;
        logic xi, xu, yi, yl;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 oe after reset", {p0_oe, p1_oe, p2_oe}, 0);
        check("R1 rdata after reset", rdata, 0);
        check("R1 latches after reset", {p0_out, p1_out, p2_out}, 0);

        // R3 / R12: random mode 0 configurations
        for (int i = 0; i < 24; i++) begin
            xi = 1'($urandom); xu = 1'($urandom); yi = 1'($urandom); yl = 1'($urandom);
            cw = {1'b1, 2'b00, xi, xu, 1'b0, yi, yl};
            cpu_wr(2'd3, cw);
            check("R2 enables released", {p0_oe, p1_oe, p2_oe}, 0);
            m0 = 8'($urandom); m1 = 8'($urandom); m2 = 8'($urandom);
            cpu_wr(2'd0, m0); cpu_wr(2'd1, m1); cpu_wr(2'd2, m2);
            p0_in = 8'($urandom); p1_in = 8'($urandom); p2_in = 8'($urandom);
            eo2 = exp_p2oe(xu, yl);
            check("R3 p0 oe", p0_oe, xi ? 8'h00 : 8'hFF);
            check("R3 p1 oe", p1_oe, yi ? 8'h00 : 8'hFF);
            check("R3 p2 oe", p2_oe, eo2);
            check("R3 p0 drive", p0_out, m0);
            cpu_rd(2'd0, r);
            check("R3 p0 read", r, xi ? p0_in : m0);
            cpu_rd(2'd1, r);
            check("R3 p1 read", r, yi ? p1_in : m1);
            cpu_rd(2'd2, r);
            check("R12 p2 read", r, exp_rd(eo2, m2, p2_in));
        end
        p2_in = '1;

        // R5: hold and control address
        cpu_rd(2'd1, hold);
        @(negedge clk);
        check("R5 rdata holds", rdata, hold);
        cpu_rd(2'd3, r);
        check("R5 control reads zero", r, 0);

        // R4: single-bit commands with all lines output
        cpu_wr(2'd3, 8'h80);
        model = '0;
        for (int i = 0; i < 20; i++) begin
            logic [2:0] idx;
            logic       v;
            idx = 3'($urandom); v = 1'($urandom);
            cpu_wr(2'd3, {4'b0000, idx, v});
            model[idx] = v;
            check("R4 bit command", p2_out, model);
        end

        // R6 R7: group Y mode 1 input
        cpu_wr(2'd3, 8'hBF);
        cpu_wr(2'd3, 8'h05);
        check("R6 strobe pin not driven", p2_oe[2], 0);
        check("R6 full idle low", p2_out[1], 0);
        p1_in = 8'h5A;
        pulse(2);
        p1_in = 8'hFF;
        check("R6 full after strobe", p2_out[1], 1);
        check("R7 irq when enabled", p2_out[0], 1);
        cpu_rd(2'd1, r);
        check("R6 captured byte", r, 8'h5A);
        check("R6 full cleared by read", p2_out[1], 0);
        check("R7 irq cleared by read", p2_out[0], 0);
        cpu_wr(2'd3, 8'h04);
        p1_in = 8'h33;
        pulse(2);
        check("R7 irq masked", {p2_out[1], p2_out[0]}, 2'b10);
        cpu_rd(2'd1, r);
        check("R6 second capture", r, 8'h33);

        // R8: group Y mode 1 output
        cpu_wr(2'd3, 8'hBD);
        cpu_wr(2'd3, 8'h05);
        check("R8 output-full idle high", p2_out[1], 1);
        cpu_wr(2'd1, 8'hC3);
        check("R8 p1 driven", {p1_oe, p1_out}, 16'hFFC3);
        check("R8 output-full low", p2_out[1], 0);
        check("R8 no irq while full", p2_out[0], 0);
        pulse(2);
        check("R8 ack releases", p2_out[1], 1);
        check("R7 output irq", p2_out[0], 1);
        cpu_wr(2'd1, 8'h11);
        check("R8 write drops irq", {p2_out[1], p2_out[0]}, 2'b00);

        // R9: group X mode 1 input
        cpu_wr(2'd3, 8'hBB);
        cpu_wr(2'd3, 8'h09);
        check("R9 handshake enables", {p2_oe[5], p2_oe[4], p2_oe[3]}, 3'b101);
        p0_in = 8'h96;
        pulse(4);
        check("R9 full and irq", {p2_out[5], p2_out[3]}, 2'b11);
        cpu_rd(2'd0, r);
        check("R9 captured byte", r, 8'h96);
        check("R9 cleared by read", {p2_out[5], p2_out[3]}, 2'b00);

        // R10: group X mode 1 output
        cpu_wr(2'd3, 8'hAB);
        cpu_wr(2'd3, 8'h0D);
        cpu_wr(2'd0, 8'h3C);
        check("R10 p0 driven", {p0_oe, p0_out}, 16'hFF3C);
        check("R10 output-full low", p2_out[7], 0);
        pulse(6);
        check("R10 ack releases with irq", {p2_out[7], p2_out[3]}, 2'b11);

        // R11: group X mode 2
        cpu_wr(2'd3, 8'hDB);
        cpu_wr(2'd3, 8'h09);
        cpu_wr(2'd3, 8'h0D);
        check("R11 bus released without ack", p0_oe, 0);
        cpu_wr(2'd0, 8'hE7);
        check("R11 output-full low", p2_out[7], 0);
        check("R11 still released", p0_oe, 0);
        @(negedge clk);
        p2_in[6] = 1'b0;
        #1;
        check("R11 driven during ack", {p0_oe, p0_out}, 16'hFFE7);
        @(negedge clk);
        p2_in[6] = 1'b1;
        #1;
        check("R11 released after ack", p0_oe, 0);
        check("R11 output done irq", {p2_out[7], p2_out[3]}, 2'b11);
        p0_in = 8'h42;
        pulse(4);
        check("R11 input full", p2_out[5], 1);
        cpu_rd(2'd0, r);
        check("R11 captured byte", r, 8'h42);
        check("R11 irq held by output side", p2_out[3], 1);
        cpu_wr(2'd0, 8'h01);
        check("R11 irq cleared", p2_out[3], 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule